// File: doc/BRIEF.md
# Programmable CIC Decimator with Output Gain

This block converts a one-bit oversampled pulse-density stream into signed multi-bit samples at a lower rate. It uses a cascade of integrators running at the input rate and a cascade of combs running at the output rate. Each accepted input bit counts as +1 or -1. Both the number of active stages and the decimation ratio are taken from configuration inputs on every cycle, so they can be changed while the filter runs. The comb result is scaled by an unsigned integer multiplier and then shifted right arithmetically. This gives a gain of mult / 2^shift.

A filter-enable input gates the whole datapath. While it is low, every integrator, comb delay, the decimation counter and the output register are forced to zero. A typical setting is seven stages, a ratio of eight, a multiplier of 0x80 and a shift of 21.

Top module: `cic_decimator`

## Requirements
- R1: While `filt_en` is low (or `rst` is high), all filter state is cleared. From the following cycle `pcm_valid` is 0 and `pcm_data` is 0, and after re-enable the filter behaves as if just reset.
- R2: An accepted input bit of 1 enters the first integrator as +1 and a bit of 0 as -1. All integrator and comb arithmetic wraps in two's complement over an accumulator of 1 + MAX_STAGES*5 bits.
- R3: On each accepted sample, integrator stage i (i below the active count S) adds to itself the value that stage i-1 held before that clock edge. Stage 0 adds the mapped input instead.
- R4: The block counts accepted samples. On an accepted sample for which the count is at least (ratio - 1), it emits one output and the count returns to 0. `pcm_valid` is high for exactly the one cycle after that sample's clock edge. A ratio field of 0 acts as 1.
- R5: At an emission, the comb chain takes the post-update value of the last active integrator. Each of the S combs outputs its input minus the input it saw at the previous emission, and then stores the new input.
- R6: The active stage count S is `cfg_stages` (4 bits, capped at MAX_STAGES). Stages at index S and above are bypassed in both chains and their state is held at zero. With S = 0 the mapped input bit reaches the gain stage directly.
- R7: The emitted sample is the low OUT_W bits of (comb result × `cfg_mult`) arithmetically shifted right by `cfg_shift`. `cfg_mult` is 8-bit unsigned and `cfg_shift` is 6 bits. `pcm_data` holds its value between emissions.
- R8: Configuration changes take effect at the next clock edge without a restart. If the ratio is lowered below the current count, the next accepted sample emits.
- R9: A cycle with `pdm_valid` low changes no integrator, comb or counter state and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | Filter enable; low clears all state |
| pdm_bit | input | 1 | One-bit density-modulated sample |
| pdm_valid | input | 1 | Strobe marking `pdm_bit` as a new sample |
| cfg_stages | input | 4 | Active integrator/comb stage count |
| cfg_ratio | input | 5 | Decimation ratio (0 treated as 1) |
| cfg_mult | input | 8 | Unsigned gain multiplier |
| cfg_shift | input | 6 | Arithmetic right shift after the multiply |
| pcm_data | output | OUT_W | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle strobe for a new `pcm_data` |

## Verification
Two functions can land on the same clock edge: an emission, and a configuration change that moves the emission point or the stage boundary. The bench provokes this by lowering the ratio below the running count and raising the stage count mid-stream, with no disable in between. It then checks that the strobe appears on the very next accepted sample and that the newly enabled stages start from zero. It also drops `filt_en` on a cycle that would otherwise emit, and judges that no strobe appears and the output reads zero. Every cycle is compared against an arithmetic model of the integrator, comb and gain equations kept in the bench.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int STG_W  = 4;
    localparam int RAT_W  = 5;
    localparam int MULT_W = 8;
    localparam int SHF_W  = 6;

    typedef struct packed {
        logic [STG_W-1:0]  stages;
        logic [RAT_W-1:0]  ratio;
        logic [MULT_W-1:0] mult;
        logic [SHF_W-1:0]  shift;
    } cic_cfg_t;

    // map a density bit to a signed +1 / -1
    function automatic logic signed [1:0] bit_to_pm(input logic b);
        return b ? 2'sb01 : 2'sb11;
    endfunction

    // ratio of zero behaves as one
    function automatic logic [RAT_W-1:0] eff_ratio(input logic [RAT_W-1:0] r);
        return (r == '0) ? RAT_W'(1) : r;
    endfunction
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
    import cic_pkg::*;
#(
    parameter int MAX_STAGES = 15,
    parameter int ACC_W      = 76
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    step,
    input  logic [STG_W-1:0]        stg,
    input  logic signed [ACC_W-1:0] x_in,
    output logic signed [ACC_W-1:0] sel_out
);
    logic signed [ACC_W-1:0] acc_q   [MAX_STAGES];
    logic signed [ACC_W-1:0] acc_nxt [MAX_STAGES];

    for (genvar i = 0; i < MAX_STAGES; i++) begin : g_stage
        logic active;
        logic signed [ACC_W-1:0] src;
        assign active = (32'(stg) > i);
        if (i == 0) begin : g_first
            assign src = x_in;
        end else begin : g_rest
            assign src = acc_q[i-1];
        end
        assign acc_nxt[i] = !active ? '0 : (step ? acc_q[i] + src : acc_q[i]);

        always_ff @(posedge clk) begin
            if (rst || !en) acc_q[i] <= '0;
            else            acc_q[i] <= acc_nxt[i];
        end

        // bypassed integrators hold zero (R6)
        assert_integ_bypass_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (32'(stg) <= i) |=> (acc_q[i] == '0));
    end

    always_comb begin
        sel_out = x_in;
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (32'(stg) == i + 1) sel_out = acc_nxt[i];
        end
    end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
    import cic_pkg::*;
#(
    parameter int MAX_STAGES = 15,
    parameter int ACC_W      = 76
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    fire,
    input  logic [STG_W-1:0]        stg,
    input  logic signed [ACC_W-1:0] u_in,
    output logic signed [ACC_W-1:0] y_out
);
    logic signed [ACC_W-1:0] u [MAX_STAGES+1];
    logic signed [ACC_W-1:0] dly_q [MAX_STAGES];

    assign u[0] = u_in;

    for (genvar i = 0; i < MAX_STAGES; i++) begin : g_stage
        logic active;
        assign active = (32'(stg) > i);
        assign u[i+1] = active ? (u[i] - dly_q[i]) : u[i];

        always_ff @(posedge clk) begin
            if (rst || !en || !active) dly_q[i] <= '0;
            else if (fire)             dly_q[i] <= u[i];
        end

        // bypassed comb delays hold zero (R6)
        assert_comb_bypass_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (32'(stg) <= i) |=> (dly_q[i] == '0));
    end

    assign y_out = u[MAX_STAGES];
endmodule

// File: rtl/cic_gain.sv
module cic_gain
    import cic_pkg::*;
#(
    parameter int ACC_W = 76,
    parameter int OUT_W = 24
) (
    input  logic signed [ACC_W-1:0] din,
    input  logic [MULT_W-1:0]       mult,
    input  logic [SHF_W-1:0]        shift,
    output logic signed [OUT_W-1:0] dout
);
    localparam int P_W = ACC_W + MULT_W + 1;

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] shd;
    logic signed [MULT_W:0] mult_s;

    assign mult_s = $signed({1'b0, mult});
    assign prod   = P_W'(din) * P_W'(mult_s);
    assign shd    = prod >>> shift;
    assign dout   = shd[OUT_W-1:0];
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
    import cic_pkg::*;
#(
    parameter int MAX_STAGES = 15,
    parameter int OUT_W      = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    filt_en,
    input  logic                    pdm_bit,
    input  logic                    pdm_valid,
    input  logic [3:0]              cfg_stages,
    input  logic [4:0]              cfg_ratio,
    input  logic [7:0]              cfg_mult,
    input  logic [5:0]              cfg_shift,
    output logic signed [OUT_W-1:0] pcm_data,
    output logic                    pcm_valid
);
    localparam int ACC_W = 1 + MAX_STAGES * RAT_W;

    cic_cfg_t cfg;
    assign cfg = '{stages: cfg_stages, ratio: cfg_ratio, mult: cfg_mult, shift: cfg_shift};

    logic [STG_W-1:0]        stg_eff;
    logic [RAT_W-1:0]        rat_eff;
    logic [RAT_W-1:0]        cnt_q;
    logic                    step, fire;
    logic signed [ACC_W-1:0] x_ext, integ_sel, comb_y;
    logic signed [OUT_W-1:0] gain_y;

    assign stg_eff = (32'(cfg.stages) > MAX_STAGES) ? STG_W'(MAX_STAGES) : cfg.stages;
    assign rat_eff = eff_ratio(cfg.ratio);
    assign x_ext   = ACC_W'(bit_to_pm(pdm_bit));
    assign step    = pdm_valid && filt_en;
    assign fire    = step && (cnt_q >= rat_eff - RAT_W'(1));

    cic_integ_chain #(.MAX_STAGES(MAX_STAGES), .ACC_W(ACC_W)) integ_i (
        .clk(clk), .rst(rst), .en(filt_en), .step(step), .stg(stg_eff),
        .x_in(x_ext), .sel_out(integ_sel)
    );

    cic_comb_chain #(.MAX_STAGES(MAX_STAGES), .ACC_W(ACC_W)) comb_i (
        .clk(clk), .rst(rst), .en(filt_en), .fire(fire), .stg(stg_eff),
        .u_in(integ_sel), .y_out(comb_y)
    );

    cic_gain #(.ACC_W(ACC_W), .OUT_W(OUT_W)) gain_i (
        .din(comb_y), .mult(cfg.mult), .shift(cfg.shift), .dout(gain_y)
    );

    always_ff @(posedge clk) begin
        if (rst || !filt_en) begin
            cnt_q     <= '0;
            pcm_valid <= 1'b0;
            pcm_data  <= '0;
        end else begin
            pcm_valid <= fire;
            if (fire)      pcm_data <= gain_y;
            if (step)      cnt_q    <= fire ? '0 : cnt_q + RAT_W'(1);
        end
    end

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !filt_en |=> (!pcm_valid && pcm_data == '0));

    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> $past(pdm_valid && filt_en));

    assert_idle_no_count_R9: assert property (@(posedge clk) disable iff (rst)
        (!pdm_valid && filt_en) |=> $stable(cnt_q));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(pdm_valid) |-> !pcm_valid);
endmodule

// File: tb/cic_decimator_tb_top.sv
module cic_decimator_tb_top;
    localparam int MAXS  = 15;
    localparam int OUT_W = 24;
    localparam int ACC_W = 1 + MAXS * 5;
    localparam int P_W   = ACC_W + 9;

    logic clk = 0, rst = 1, filt_en = 0, pdm_bit = 0, pdm_valid = 0;
    logic [3:0] cfg_stages = 0;
    logic [4:0] cfg_ratio = 1;
    logic [7:0] cfg_mult = 1;
    logic [5:0] cfg_shift = 0;
    logic signed [OUT_W-1:0] pcm_data;
    logic pcm_valid;

    always #2.5 clk = ~clk;

    cic_decimator #(.MAX_STAGES(MAXS), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst(rst), .filt_en(filt_en), .pdm_bit(pdm_bit),
        .pdm_valid(pdm_valid), .cfg_stages(cfg_stages), .cfg_ratio(cfg_ratio),
        .cfg_mult(cfg_mult), .cfg_shift(cfg_shift),
        .pcm_data(pcm_data), .pcm_valid(pcm_valid)
    );

    int n_vec = 0, n_bad = 0;
    logic signed [ACC_W-1:0] mi [MAXS];
    logic signed [ACC_W-1:0] md [MAXS];
    int cnt = 0;
    logic ev = 0;
    logic signed [OUT_W-1:0] held = 0;
    string tag = "R1";

    task automatic model_clear();
        for (int i = 0; i < MAXS; i++) begin mi[i] = 0; md[i] = 0; end
        cnt = 0; ev = 0; held = 0;
    endtask

    task automatic model_step(input logic en, input logic v, input logic b);
        int s, r;
        logic signed [ACC_W-1:0] x, u, c;
        logic signed [P_W-1:0] prod;
        logic fire;
        s = int'(cfg_stages); r = (cfg_ratio == 0) ? 1 : int'(cfg_ratio);
        if (!en) begin model_clear(); return; end
        x = b ? ACC_W'(1) : -ACC_W'(1);
        if (v) for (int i = s - 1; i >= 0; i--) mi[i] = mi[i] + ((i == 0) ? x : mi[i-1]);
        u = (s == 0) ? x : mi[s-1];
        for (int i = s; i < MAXS; i++) begin mi[i] = 0; md[i] = 0; end
        fire = v && (cnt >= r - 1);
        if (v) cnt = fire ? 0 : cnt + 1;
        if (fire) begin
            for (int i = 0; i < s; i++) begin c = u - md[i]; md[i] = u; u = c; end
            prod = P_W'(u) * P_W'($signed({1'b0, cfg_mult}));
            prod = prod >>> cfg_shift;
            held = prod[OUT_W-1:0];
        end
        ev = fire;
    endtask

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp_v, $time);
        end
    endtask

    // entered at a negative edge
    task automatic step(input logic en, input logic v, input logic b);
        filt_en = en; pdm_valid = v; pdm_bit = b;
        @(posedge clk);
        model_step(en, v, b);
        @(negedge clk);
        check({tag, " strobe (R4)"}, 64'(pcm_valid), 64'(ev));
        check({tag, " data (R7)"}, 64'($signed(pcm_data)), 64'($signed(held)));
    endtask

    task automatic run(input int n, input int vpct);
        for (int k = 0; k < n; k++) step(1'b1, ($urandom % 100) < vpct, $urandom % 2);
    endtask

    task automatic cfg_run(input int s, input int r, input int m, input int sh, input int n, input string t);
        tag = "R1";
        step(1'b0, 1'b1, 1'b1);              // disable cycle clears state (R1)
        cfg_stages = 4'(s); cfg_ratio = 5'(r); cfg_mult = 8'(m); cfg_shift = 6'(sh);
        tag = t;
        run(n, 75);
    endtask

    initial begin
        int wd = 0;
        fork
            begin
                model_clear();
                repeat (3) @(posedge clk);
                @(negedge clk); rst = 0;
                check("R1 reset strobe", 64'(pcm_valid), 0);
                check("R1 reset data", 64'(pcm_data), 0);
                cfg_run(0, 1, 1, 0, 60, "R2");       // raw +/-1 path, S=0 (R2, R6)
                cfg_run(1, 2, 1, 0, 80, "R3");
                cfg_run(2, 4, 3, 0, 120, "R5");
                cfg_run(3, 3, 8'h80, 7, 150, "R5");
                cfg_run(7, 8, 8'h80, 21, 400, "R5");  // typical setting
                cfg_run(4, 0, 5, 2, 100, "R4");       // ratio 0 acts as 1
                cfg_run(15, 31, 255, 40, 800, "R6");  // full depth
                cfg_run(5, 6, 9, 3, 200, "R9");       // sparse valids
                run(200, 20);
                // R8: lower ratio below the running count, grow the stage count
                cfg_run(3, 8, 16, 1, 5, "R8");
                for (int k = 0; k < 6; k++) step(1'b1, 1'b1, k % 2);
                cfg_ratio = 2; cfg_stages = 5;
                run(100, 100);
                cfg_stages = 2; cfg_ratio = 8;
                run(50, 90);
                // R1: drop enable on a cycle that would emit
                tag = "R1";
                cfg_ratio = 1;
                step(1'b0, 1'b1, 1'b1);
                step(1'b0, 1'b1, 1'b0);
                tag = "R3";
                run(40, 100);
            end
            begin
                while (wd < 150000) begin @(posedge clk); wd++; end
                n_bad++; n_vec++;
                $display("FAIL watchdog: actual expired expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule